// File: doc/BRIEF.md
# Zero-Crossing FSK Period Demodulator

This block turns the squared output of a receive comparator into NRZ data for a 1200 bit/s link that uses 1200 Hz and 2200 Hz tones, running from a 460.8 kHz time base. It synchronises the square wave, times the gap between successive transitions, and compares each gap (one half-cycle of the tone) with a fixed threshold. A long half-cycle means the 1200 Hz tone and gives a one. A short half-cycle means the 2200 Hz tone and gives a zero. At 460.8 kHz the nominal half-cycles are 192 and about 105 clocks.

The decision is gated. While the carrier-detect flag is low, or while the local transmitter is active, the output is held at idle (logic high) and the interval timer is cleared. The first transition after the gate opens only starts timing. Intervals so long that the counter saturates keep the previous decision, so a stalled comparator does not produce data.

Top module: `fsk_zc_demod`

## Requirements
- R1: While reset is asserted and after it is released, with no qualified transition yet, rx_data is 1.
- R2: A decision shows on rx_data after the third rising clock edge that follows the input transition ending the interval (two synchroniser stages plus the output register).
- R3: An interval of more than THRESH clocks (default 140), measured from one qualified transition to the next, drives rx_data to 1.
- R4: An interval of THRESH clocks or fewer drives rx_data to 0. With the default, 140 clocks gives 0 and 141 gives 1.
- R5: With the default edge selection, rising and falling transitions of rx_sq each end one interval and start the next.
- R6: The interval counter saturates at 2^CNT_W-1 (255 by default). An interval that reaches that count leaves rx_data unchanged.
- R7: While carrier_ok is 0, rx_data is 1 from the next clock on and the interval timer is cleared. The first transition after carrier_ok returns only starts timing.
- R8: While tx_busy is 1, the block behaves as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 460.8 kHz time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sq | input | 1 | Asynchronous square wave from the receive comparator |
| carrier_ok | input | 1 | Carrier-detect qualifier, high when a carrier is present |
| tx_busy | input | 1 | High while the local transmitter is active |
| rx_data | output | 1 | Recovered NRZ data; 1 at idle |

## Verification
The data decision is due at the third rising edge after an input transition. A gate change is due one edge after carrier_ok or tx_busy moves. The bench drives its inputs on falling edges. A behavioural model keeps a history of input samples and the cycle index of the last qualified transition, and at each rising edge computes the value the output must hold after that edge. The output is compared with the model at the next falling edge. One direct check also counts the three edges of R2 explicitly, so a change in latency shows up both in that check and in the per-clock comparison.

// File: rtl/fsk_zc_demod_pkg.sv
package fsk_zc_demod_pkg;
   typedef enum logic [1:0] {
      EDGE_BOTH = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } edge_sel_e;
endpackage

// File: rtl/fsk_zc_sync.sv
module fsk_zc_sync
   import fsk_zc_demod_pkg::*;
#(
   parameter int        STAGES   = 2,
   parameter edge_sel_e EDGE_SEL = EDGE_BOTH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_p
);
   logic [STAGES-1:0] chain;
   logic              prev;
   logic              lvl;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsk_zc_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl = chain[STAGES-1];

   generate
      if (EDGE_SEL == EDGE_RISE) begin : g_rise
         assign edge_p = lvl & ~prev;
      end else if (EDGE_SEL == EDGE_FALL) begin : g_fall
         assign edge_p = ~lvl & prev;
      end else begin : g_both
         assign edge_p = lvl ^ prev;
      end
   endgenerate
endmodule

// File: rtl/fsk_zc_timer.sv
module fsk_zc_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic             edge_p,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!gate) begin
         cnt <= '0;
      end else if (edge_p) begin
         cnt <= ONE;
      end else if (cnt != '0 && cnt != CMAX) begin
         cnt <= cnt + ONE;
      end
   end
endmodule

// File: rtl/fsk_zc_decide.sv
module fsk_zc_decide #(
   parameter int CNT_W  = 8,
   parameter int THRESH = 140
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic             edge_p,
   input  logic [CNT_W-1:0] cnt,
   output logic             dq
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] THR  = CNT_W'(THRESH);

   logic valid_ivl;
   assign valid_ivl = edge_p && (cnt != '0) && (cnt != CMAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq <= 1'b1;
      end else if (!gate) begin
         dq <= 1'b1;
      end else if (valid_ivl) begin
         dq <= (cnt > THR);
      end
   end
endmodule

// File: rtl/fsk_zc_demod.sv
module fsk_zc_demod
   import fsk_zc_demod_pkg::*;
#(
   parameter int        CNT_W    = 8,
   parameter int        THRESH   = 140,
   parameter int        STAGES   = 2,
   parameter edge_sel_e EDGE_SEL = EDGE_BOTH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_sq,
   input  logic carrier_ok,
   input  logic tx_busy,
   output logic rx_data
);
   generate
      if (THRESH < 1 || THRESH >= (2**CNT_W) - 1) begin : g_bad_thresh
         $error("fsk_zc_demod: THRESH must lie inside the counter range");
      end
   endgenerate

   logic             gate;
   logic             edge_pulse;
   logic [CNT_W-1:0] ivl_cnt;

   assign gate = carrier_ok & ~tx_busy;

   fsk_zc_sync #(.STAGES(STAGES), .EDGE_SEL(EDGE_SEL)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rx_sq), .edge_p(edge_pulse)
   );

   fsk_zc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .gate(gate), .edge_p(edge_pulse), .cnt(ivl_cnt)
   );

   fsk_zc_decide #(.CNT_W(CNT_W), .THRESH(THRESH)) u_decide (
      .clk(clk), .rst_n(rst_n), .gate(gate), .edge_p(edge_pulse),
      .cnt(ivl_cnt), .dq(rx_data)
   );
endmodule

// File: rtl/fsk_zc_demod_chk.sv
module fsk_zc_demod_chk #(
   parameter int CNT_W  = 8,
   parameter int THRESH = 140
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cd,
   input logic             tx,
   input logic             edge_p,
   input logic [CNT_W-1:0] cnt,
   input logic             rx_data
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] THR  = CNT_W'(THRESH);

   // R7 R8
   gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cd || tx) |=> rx_data);

   // R7
   gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cd || tx) |=> (cnt == '0));

   // R6
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CMAX && !edge_p && cd && !tx) |=> (cnt == CMAX));

   // R6
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CMAX && edge_p && cd && !tx) |=> $stable(rx_data));

   // R3
   long_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_p && cd && !tx && cnt > THR && cnt != CMAX) |=> rx_data);

   // R4
   short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_p && cd && !tx && cnt != '0 && cnt <= THR) |=> !rx_data);
endmodule

bind fsk_zc_demod fsk_zc_demod_chk #(.CNT_W(CNT_W), .THRESH(THRESH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cd(carrier_ok), .tx(tx_busy),
   .edge_p(edge_pulse), .cnt(ivl_cnt), .rx_data(rx_data)
);

// File: tb/fsk_zc_demod_test.sv
module fsk_zc_demod_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_sq = 1'b0;
   logic carrier_ok = 1'b0;
   logic tx_busy = 1'b0;
   logic rx_data;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #4 clk = ~clk;

   fsk_zc_demod uut (
      .clk(clk), .rst_n(rst_n), .rx_sq(rx_sq),
      .carrier_ok(carrier_ok), .tx_busy(tx_busy), .rx_data(rx_data)
   );

   // behavioural reference: input history, cycle of last qualified edge
   int  hist[$];
   int  n = 0;
   int  last = 0;
   bit  armed = 1'b0;
   bit  exp_d = 1'b1;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{0, 0, 0};
         n = 0; armed = 1'b0; exp_d = 1'b1;
      end else begin
         bit e;
         n++;
         e = (hist[hist.size()-2] != hist[hist.size()-3]);
         hist.push_back(int'(rx_sq));
         void'(hist.pop_front());
         if (!carrier_ok || tx_busy) begin
            armed = 1'b0;
            exp_d = 1'b1;
         end else if (e) begin
            if (armed && (n - last) < 255) exp_d = ((n - last) > 140);
            armed = 1'b1;
            last = n;
         end
      end
   end

   task automatic check(input string req, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: rx_data=%0b expected %0b at t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) check(cur_req, rx_data, exp_d);
   end

   task automatic half(input int k);
      rx_sq = ~rx_sq;
      repeat (k) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R1", rx_data, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", rx_data, 1'b1);
      carrier_ok = 1'b1;
      cur_req = "R3";
      for (int i = 0; i < 8; i++) half(192);
      cur_req = "R4";
      for (int i = 0; i < 10; i++) half(105);
      // R2: explicit latency after a long half-cycle following zeros
      cur_req = "R2";
      rx_sq = ~rx_sq;
      @(negedge clk); @(negedge clk);
      half(105 - 2);
      rx_sq = ~rx_sq;
      @(negedge clk); @(negedge clk);
      check("R2", rx_data, 1'b0);
      @(negedge clk);
      check("R2", rx_data, 1'b0);
      repeat (189) @(negedge clk);
      rx_sq = ~rx_sq;
      @(negedge clk); @(negedge clk);
      check("R2", rx_data, 1'b0);
      @(negedge clk);
      check("R2", rx_data, 1'b1);
      repeat (100) @(negedge clk);
      cur_req = "R4";
      for (int i = 0; i < 6; i++) begin
         half(140);
         half(141);
      end
      cur_req = "R5";
      for (int i = 0; i < 8; i++) begin
         half(192);
         half(105);
      end
      cur_req = "R6";
      half(105);
      half(300);
      half(260);
      half(105);
      half(400);
      half(192);
      half(192);
      cur_req = "R7";
      half(105);
      carrier_ok = 1'b0;
      for (int i = 0; i < 4; i++) half(105);
      carrier_ok = 1'b1;
      for (int i = 0; i < 6; i++) half(105);
      cur_req = "R8";
      tx_busy = 1'b1;
      for (int i = 0; i < 4; i++) half(105);
      @(negedge clk);
      check("R8", rx_data, 1'b1);
      tx_busy = 1'b0;
      for (int i = 0; i < 6; i++) half(105);
      for (int i = 0; i < 4; i++) half(192);
      finish_run();
   end
endmodule